// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

This block moves outgoing frames from memory to a MAC-side byte stream. Software builds a circular ring of 16-byte descriptors in memory and programs the ring's base address. It hands descriptors to the engine by moving a tail index. The engine fetches each posted descriptor, reads the buffer that descriptor points to one 32-bit word at a time, and emits the bytes on a valid/ready/last stream. A frame may be spread across several descriptors.

Software controls the engine through a small register port. It can enable the channel, hold it at a descriptor boundary, or shut it down. The shutdown finishes the descriptor already under way before the channel reports that it is off. A done flag, also driven out as an interrupt line, marks the completion of any descriptor that asks for one. The status word reports the channel state and the byte offset of the descriptor the engine will handle next.

Top module: `txdma_engine`

## Requirements
- R1: After reset the following are all zero: the state code, the done flag, `irq_done`, `out_valid`, `mem_req` and every register read-back.
- R2: Descriptor `i` is read as four 32-bit words from `base + 16*i + 4*k`, with `k` running from 0 to 3. The words are: flags, byte count in bits [15:0], buffer address bits [31:0], buffer address bits [63:32]. In the flags word, bit0 marks start of frame, bit1 marks end of frame, bit2 requests a done flag and bit3 marks end of table. Read requests are word aligned, and each request holds its address until it is acknowledged.
- R3: A descriptor's bytes leave in ascending address order, from any starting byte address, with byte lane 0 the low byte of a memory word. `out_valid` and `out_data` hold while `out_ready` is low.
- R4: `out_last` rises only with the final byte of a descriptor that has the end-of-frame flag set. A frame may span several descriptors.
- R5: The engine processes descriptors while its current index differs from the tail index and reports idle (code 2) when the two are equal. The tail register is at offset 1 and takes the index from bits [RING_W+3:4]. Its bits [3:0] read back as 0.
- R6: After a descriptor with end-of-table set, the next descriptor is index 0.
- R7: Completing a descriptor that requests a done flag sets status bit 8 and raises `irq_done`. Writing the status register (offset 4) with bit 8 set clears the flag.
- R8: With the suspend bit set, the engine stops at the next descriptor boundary and reports suspended (code 4). It fetches nothing more until the bit is cleared.
- R9: Clearing enable in the middle of a descriptor leaves the state at active (code 1) until every byte of that descriptor has been accepted. The state then becomes disabled (code 0) and the current index resets to 0.
- R10: A descriptor without start-of-frame, fetched while no frame is open, puts the channel in stopped (code 3). Nothing is streamed and the index does not advance. Only clearing enable leaves this state.
- R11: The registers are laid out as follows. Offset 0 is control: bit0 enable, bit1 suspend, bit2 parity-disable (stored and read back). Offset 2 is base low, with bits [3:0] reading 0. Offset 3 is base high. Offset 4 is status: [2:0] state, bit 8 done, [31:16] current index times 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Word-aligned read address |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Last byte of frame |
| out_ready | input | 1 | Stream sink ready |
| irq_done | output | 1 | Done flag |

## Verification
The hardest cases to reach are a suspend or a disable that arrives while a descriptor is only partly streamed. The bench creates both by holding `out_ready` low after posting work, so the engine stalls mid-buffer. It then changes the control register and releases the sink. It checks that the in-flight descriptor still completes in full, and that the state code and current index land where R8 and R9 require. The table walk uses a short ring: an end-of-table flag is set on the fifth slot, and unaligned buffers and multi-descriptor frames are mixed with sink stall patterns.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    typedef enum logic [2:0] {
        CH_OFF  = 3'd0,
        CH_RUN  = 3'd1,
        CH_IDLE = 3'd2,
        CH_HALT = 3'd3,
        CH_HOLD = 3'd4
    } chan_e;

    localparam int FL_SOF = 0;
    localparam int FL_EOF = 1;
    localparam int FL_IRQ = 2;
    localparam int FL_EOT = 3;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_TAIL = 3'd1;
    localparam logic [2:0] A_BLO  = 3'd2;
    localparam logic [2:0] A_BHI  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
    import txdma_pkg::*;
#(
    parameter int RING_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  chan_e             chan_state,
    input  logic [RING_W-1:0] cur_idx,
    input  logic              done_set,
    output logic              en,
    output logic              hold,
    output logic [63:0]       base,
    output logic [RING_W-1:0] tail_idx,
    output logic              irq
);

    typedef struct packed {
        logic              en;
        logic              hold;
        logic              pdis;
        logic [RING_W-1:0] tail;
        logic [27:0]       base_lo;
        logic [31:0]       base_hi;
        logic              done;
    } regs_t;

    regs_t d, q;
    logic [15:0] cur_off;

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    d.en   = reg_wdata[0];
                    d.hold = reg_wdata[1];
                    d.pdis = reg_wdata[2];
                end
                A_TAIL:  d.tail    = reg_wdata[RING_W+3:4];
                A_BLO:   d.base_lo = reg_wdata[31:4];
                A_BHI:   d.base_hi = reg_wdata;
                A_STAT:  if (reg_wdata[8]) d.done = 1'b0;
                default: ;
            endcase
        end
        if (done_set) d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_off = 16'(cur_idx) << 4;

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {29'd0, q.pdis, q.hold, q.en};
            A_TAIL:  reg_rdata = 32'(q.tail) << 4;
            A_BLO:   reg_rdata = {q.base_lo, 4'd0};
            A_BHI:   reg_rdata = q.base_hi;
            A_STAT:  reg_rdata = {cur_off, 7'd0, q.done, 5'd0, chan_state};
            default: reg_rdata = 32'd0;
        endcase
    end

    assign en       = q.en;
    assign hold     = q.hold;
    assign base     = {q.base_hi, q.base_lo, 4'd0};
    assign tail_idx = q.tail;
    assign irq      = q.done;

    // R7: a clearing write with no simultaneous completion drops the flag
    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata[8] && !done_set) |=> !irq);

    // R11: the reported state is always one of the five legal codes
    assert_state_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chan_state inside {CH_OFF, CH_RUN, CH_IDLE, CH_HALT, CH_HOLD});

endmodule

// File: rtl/txdma_packer.sv
module txdma_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_word,
    input  logic [1:0]  in_lane,
    input  logic [2:0]  in_n,
    input  logic        in_last,
    output logic        empty,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    input  logic        out_ready
);

    typedef struct packed {
        logic        busy;
        logic [31:0] word;
        logic [1:0]  lane;
        logic [2:0]  left;
        logic        last;
    } pk_t;

    pk_t d, q;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (in_valid) begin
                d.busy = 1'b1;
                d.word = in_word;
                d.lane = in_lane;
                d.left = in_n;
                d.last = in_last;
            end
        end else if (out_ready) begin
            d.left = q.left - 3'd1;
            d.lane = q.lane + 2'd1;
            if (q.left == 3'd1) d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready  = !q.busy;
    assign empty     = !q.busy;
    assign out_valid = q.busy;
    assign out_data  = 8'(q.word >> {q.lane, 3'b000});
    assign out_last  = q.busy && q.last && (q.left == 3'd1);

    // R3: a stalled byte stays put
    assert_hold_while_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
    import txdma_pkg::*;
#(
    parameter int RING_W  = 3,
    parameter int COUNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hold,
    input  logic [63:0]       base,
    input  logic [RING_W-1:0] tail_idx,
    output chan_e             state,
    output logic [RING_W-1:0] cur_idx,
    output logic              done_set,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              pk_valid,
    input  logic              pk_ready,
    output logic [31:0]       pk_word,
    output logic [1:0]        pk_lane,
    output logic [2:0]        pk_n,
    output logic              pk_last,
    input  logic              pk_empty
);

    typedef enum logic [2:0] {
        P_IDLE, P_DREQ, P_DWAIT, P_BREQ, P_BWAIT, P_PUSH, P_DRAIN
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        chan_e              st;
        logic [RING_W-1:0]  cur;
        logic [1:0]         wsel;
        logic [3:0]         flags;
        logic [COUNT_W-1:0] remain;
        logic [63:0]        baddr;
        logic               open;
        logic               halt;
        logic [31:0]        word;
        logic               done;
    } ctl_t;

    ctl_t d, q;
    logic [63:0] desc_addr;
    logic [2:0]  room, take;

    function automatic ctl_t retire(ctl_t s);
        s.done  = s.flags[FL_IRQ];
        s.open  = !s.flags[FL_EOF];
        s.cur   = s.flags[FL_EOT] ? '0 : s.cur + 1'b1;
        s.phase = P_IDLE;
        return s;
    endfunction

    assign desc_addr = base + (64'(q.cur) << 4) + (64'(q.wsel) << 2);
    assign room      = 3'd4 - {1'b0, q.baddr[1:0]};
    assign take      = (q.remain < COUNT_W'(room)) ? q.remain[2:0] : room;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        mem_req  = 1'b0;
        mem_addr = desc_addr;
        pk_valid = 1'b0;
        case (q.phase)
            P_IDLE: begin
                if (!en) begin
                    d.st   = CH_OFF;
                    d.cur  = '0;
                    d.halt = 1'b0;
                    d.open = 1'b0;
                end else if (q.halt) begin
                    d.st = CH_HALT;
                end else if (hold) begin
                    d.st = CH_HOLD;
                end else if (q.cur == tail_idx) begin
                    d.st = CH_IDLE;
                end else begin
                    d.st    = CH_RUN;
                    d.wsel  = 2'd0;
                    d.phase = P_DREQ;
                end
            end
            P_DREQ: begin
                mem_req = 1'b1;
                if (mem_ack) d.phase = P_DWAIT;
            end
            P_DWAIT: begin
                if (mem_rvalid) begin
                    case (q.wsel)
                        2'd0: d.flags         = mem_rdata[3:0];
                        2'd1: d.remain        = mem_rdata[COUNT_W-1:0];
                        2'd2: d.baddr[31:0]   = mem_rdata;
                        default: d.baddr[63:32] = mem_rdata;
                    endcase
                    if (q.wsel != 2'd3) begin
                        d.wsel  = q.wsel + 2'd1;
                        d.phase = P_DREQ;
                    end else if (!q.open && !q.flags[FL_SOF]) begin
                        d.halt  = 1'b1;
                        d.st    = CH_HALT;
                        d.phase = P_IDLE;
                    end else if (q.remain == '0) begin
                        d = retire(d);
                    end else begin
                        d.phase = P_BREQ;
                    end
                end
            end
            P_BREQ: begin
                mem_req  = 1'b1;
                mem_addr = {q.baddr[63:2], 2'b00};
                if (mem_ack) d.phase = P_BWAIT;
            end
            P_BWAIT: begin
                if (mem_rvalid) begin
                    d.word  = mem_rdata;
                    d.phase = P_PUSH;
                end
            end
            P_PUSH: begin
                pk_valid = 1'b1;
                if (pk_ready) begin
                    d.baddr  = q.baddr + 64'(take);
                    d.remain = q.remain - COUNT_W'(take);
                    d.phase  = (q.remain == COUNT_W'(take)) ? P_DRAIN : P_BREQ;
                end
            end
            P_DRAIN: begin
                if (pk_empty) d = retire(d);
            end
            default: d.phase = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign state    = q.st;
    assign cur_idx  = q.cur;
    assign done_set = q.done;
    assign pk_word  = q.word;
    assign pk_lane  = q.baddr[1:0];
    assign pk_n     = take;
    assign pk_last  = q.flags[FL_EOF] && (q.remain == COUNT_W'(take));

    // R2: an unaccepted request keeps its address
    assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2: requests are word aligned
    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R9: an off channel always sits at index 0
    assert_off_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_OFF) |-> (cur_idx == '0));

    // R8: a suspended channel fetches nothing
    assert_hold_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_HOLD) |-> !mem_req);

    // R10: a stopped channel fetches nothing
    assert_halt_no_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_HALT) |-> !mem_req);

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int RING_W  = 3,
    parameter int COUNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_ack,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    input  logic        out_ready,
    output logic        irq_done
);

    chan_e             chan_state;
    logic [RING_W-1:0] cur_idx, tail_idx;
    logic              done_set, en, hold;
    logic [63:0]       base;
    logic              pk_valid, pk_ready, pk_last, pk_empty;
    logic [31:0]       pk_word;
    logic [1:0]        pk_lane;
    logic [2:0]        pk_n;

    txdma_regs #(.RING_W(RING_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_state(chan_state), .cur_idx(cur_idx), .done_set(done_set),
        .en(en), .hold(hold), .base(base), .tail_idx(tail_idx), .irq(irq_done)
    );

    txdma_ctrl #(.RING_W(RING_W), .COUNT_W(COUNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .en(en), .hold(hold), .base(base), .tail_idx(tail_idx),
        .state(chan_state), .cur_idx(cur_idx), .done_set(done_set),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_word(pk_word),
        .pk_lane(pk_lane), .pk_n(pk_n), .pk_last(pk_last), .pk_empty(pk_empty)
    );

    txdma_packer u_pack (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pk_valid), .in_ready(pk_ready), .in_word(pk_word),
        .in_lane(pk_lane), .in_n(pk_n), .in_last(pk_last), .empty(pk_empty),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

endmodule

// File: tb/tb_txdma_engine.sv
module tb_txdma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_ack;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        out_valid, out_last, irq_done;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;

    always #10 clk = ~clk;

    txdma_engine dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .irq_done(irq_done)
    );

    // memory model: accepts at once, answers one cycle later
    logic [7:0] mem [0:1023];
    assign mem_ack = mem_req;
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= {mem[mem_addr[9:0]+3], mem[mem_addr[9:0]+2],
                       mem[mem_addr[9:0]+1], mem[mem_addr[9:0]]};
    end

    // stream sink
    int   cyc = 0;
    int   stall = 0;
    logic sink_hold = 1'b0;
    logic [7:0] got_b[$], exp_b[$];
    logic       got_l[$], exp_l[$];
    always @(negedge clk) begin
        cyc++;
        out_ready = !sink_hold && ((cyc % 4) >= stall);
        if (out_valid && out_ready) begin
            got_b.push_back(out_data);
            got_l.push_back(out_last);
        end
    end

    int total = 0;
    int bad = 0;

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_state(input logic [2:0] code);
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(3'd4, v);
            if (v[2:0] == code) break;
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a+k] = v[8*k +: 8];
    endtask

    // write descriptor into ring slot and model the bytes it should produce
    task automatic post(input int slot, input logic [3:0] fl, input int cnt, input int ba);
        int d;
        d = 'h100 + slot * 16;
        put_word(d, {28'd0, fl});
        put_word(d + 4, cnt);
        put_word(d + 8, ba);
        put_word(d + 12, 32'd0);
        for (int i = 0; i < cnt; i++) begin
            exp_b.push_back(mem[ba+i]);
            exp_l.push_back(fl[1] && (i == cnt - 1));
        end
    endtask

    task automatic cmp_stream(input string what);
        logic ok;
        ok = (got_b.size() == exp_b.size());
        if (ok) begin
            for (int i = 0; i < got_b.size(); i++)
                if (got_b[i] !== exp_b[i] || got_l[i] !== exp_l[i]) ok = 1'b0;
        end
        chk(ok, what, got_b.size(), exp_b.size());
        got_b.delete(); got_l.delete(); exp_b.delete(); exp_l.delete();
    endtask

    // [31:20] buffer address, [19:8] byte count, [7:4] sink stall, [3:0] flags
    localparam logic [31:0] VEC [10] = '{
        {12'h201, 12'd5, 4'd0, 4'h7},
        {12'h210, 12'd8, 4'd1, 4'h3},
        {12'h223, 12'd1, 4'd2, 4'h7},
        {12'h233, 12'd6, 4'd0, 4'h1},
        {12'h240, 12'd3, 4'd3, 4'hE},
        {12'h251, 12'd9, 4'd0, 4'h7},
        {12'h262, 12'd4, 4'd2, 4'h3},
        {12'h270, 12'd2, 4'd1, 4'h1},
        {12'h281, 12'd2, 4'd0, 4'h0},
        {12'h292, 12'd7, 4'd1, 4'h6}
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int slot, nxt;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(3'd4, v);
        chk(v == 32'd0 && !irq_done && !out_valid && !mem_req, "R1 reset status/outputs", v, 0);
        rd(3'd0, v);
        chk(v == 32'd0, "R1 reset control", v, 0);
        rst_n = 1'b1;
        // R11 register map before enabling
        wr(3'd0, 32'h4);
        rd(3'd0, v);
        chk(v == 32'h4, "R11 control readback", v, 32'h4);
        wr(3'd2, 32'h10F);
        rd(3'd2, v);
        chk(v == 32'h100, "R11 base low masked", v, 32'h100);
        wr(3'd3, 32'h0);
        rd(3'd3, v);
        chk(v == 32'h0, "R11 base high", v, 0);
        wr(3'd1, 32'h1F);
        rd(3'd1, v);
        chk(v == 32'h10, "R5 tail low bits read 0", v, 32'h10);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h1);
        wait_state(3'd2);
        rd(3'd4, v);
        chk(v[2:0] == 3'd2, "R5 idle with empty ring", v[2:0], 2);

        // table walk: R2 R3 R4 R5 R6 R7
        slot = 0;
        foreach (VEC[e]) begin
            stall = int'(VEC[e][7:4]);
            post(slot, VEC[e][3:0], int'(VEC[e][19:8]), int'(VEC[e][31:20]));
            nxt = VEC[e][3] ? 0 : (slot + 1) % 8;
            wr(3'd1, nxt * 16);
            repeat (2) @(negedge clk);
            wait_state(3'd2);
            cmp_stream($sformatf("R3/R4 stream entry %0d", e));
            rd(3'd4, v);
            chk(v[31:16] == nxt * 16, $sformatf("R6 current offset entry %0d", e), v[31:16], nxt * 16);
            chk(irq_done == VEC[e][2], $sformatf("R7 done flag entry %0d", e), irq_done, VEC[e][2]);
            if (irq_done) begin
                wr(3'd4, 32'h100);
                chk(!irq_done, "R7 done cleared", irq_done, 0);
            end
            slot = nxt;
        end
        stall = 0;

        // R8 suspend before posting: slot 5
        wr(3'd0, 32'h3);
        post(5, 4'h3, 4, 'h2A1);
        wr(3'd1, 6 * 16);
        repeat (30) @(negedge clk);
        rd(3'd4, v);
        chk(v[2:0] == 3'd4 && v[31:16] == 16'd80 && got_b.size() == 0,
            "R8 suspended without fetching", v, 32'h0050_0004);
        wr(3'd0, 32'h1);
        repeat (2) @(negedge clk);
        wait_state(3'd2);
        cmp_stream("R8 resume stream");

        // R8 suspend while mid-descriptor: slots 6 and 7 (7 ends table)
        sink_hold = 1'b1;
        post(6, 4'h3, 6, 'h2B1);
        wr(3'd1, 32'h0);
        repeat (30) @(negedge clk);
        wr(3'd0, 32'h3);
        post(7, 4'hB, 3, 'h2C2);
        sink_hold = 1'b0;
        repeat (2) @(negedge clk);
        wait_state(3'd4);
        rd(3'd4, v);
        chk(v[2:0] == 3'd4 && v[31:16] == 16'd112, "R8 stops at boundary mid-ring", v, 32'h0070_0004);
        chk(got_b.size() == 6, "R8 in-flight descriptor completed", got_b.size(), 6);
        wr(3'd0, 32'h1);
        repeat (2) @(negedge clk);
        wait_state(3'd2);
        cmp_stream("R8/R6 stream across suspend");
        rd(3'd4, v);
        chk(v[31:16] == 16'd0, "R6 wrap after end-of-table", v[31:16], 0);

        // R9 disable mid-descriptor
        sink_hold = 1'b1;
        post(0, 4'h3, 6, 'h2D3);
        wr(3'd1, 32'h10);
        repeat (30) @(negedge clk);
        wr(3'd0, 32'h0);
        repeat (10) @(negedge clk);
        rd(3'd4, v);
        chk(v[2:0] == 3'd1, "R9 still active while draining", v[2:0], 1);
        sink_hold = 1'b0;
        wait_state(3'd0);
        rd(3'd4, v);
        chk(v[2:0] == 3'd0 && v[31:16] == 16'd0, "R9 disabled, index reset", v, 0);
        cmp_stream("R9 drained stream complete");

        // R10 descriptor without start of frame
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h1);
        mem['h100] = 8'h02;
        wr(3'd1, 32'h10);
        repeat (30) @(negedge clk);
        rd(3'd4, v);
        chk(v[2:0] == 3'd3 && v[31:16] == 16'd0 && got_b.size() == 0,
            "R10 stopped, nothing streamed", v, 32'h3);
        wr(3'd0, 32'h0);
        wait_state(3'd0);
        rd(3'd4, v);
        chk(v[2:0] == 3'd0, "R10 disable leaves stopped", v[2:0], 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule